// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control around a delta-sigma converter. Software writes a channel-select field to start either a run of conversions over channels 0 up to the written value, or one conversion of a single high-numbered channel. A separate extra-channel field starts a one-off conversion that the block slips in between sequence conversions when needed. The block divides the system clock by six to form the converter clock, counts a fixed settling time plus the decimation length in converter periods, and at the end captures the converter model's signed sample.

Each result is stored left-justified in a 16-bit register and flagged by an end-of-conversion bit that a read of the high byte clears. The channel-select readback reports what ran last. Sequence and single conversions pulse a per-channel DMA trigger and a shared all-channels trigger. Extra conversions pulse only the interrupt.

Top module: `adcseq_top`

## Requirements
- R1: The converter clock is the system clock divided by 6. A conversion lasts 6*(16 + D) system cycles, where D is the decimation length. The first completion is seen 6*(16 + D) cycles after the clock edge that accepts the start write, and back-to-back conversions are spaced by the same amount.
- R2: A write with `wr_sel` = 2 loads the decimation code from `wr_data[1:0]`: 0 gives D = 64, 1 gives 128, 2 gives 256 and 3 gives 512. Reset selects code 0. A new code takes effect at the next conversion start.
- R3: `result` holds the captured 12-bit two's-complement sample in bits [15:4], with bits [3:0] at zero.
- R4: After reset, `result`, `eoc`, `sch_rd`, `irq`, `dma_ch` and `dma_all` are all zero. `eoc` rises with each completion and is cleared by a one-cycle `rd_hi` strobe.
- R5: A channel-select write (`wr_sel` = 0) of a value v below 12 converts channels 0, 1, ... v in order, back to back. After the last conversion, `sch_rd` reads v + 1.
- R6: A channel-select write of a value v of 12 or more converts only channel v. Afterwards `sch_rd` reads v.
- R7: An extra-channel write (`wr_sel` = 1) of value e starts one conversion of channel e. On completion `sch_rd` becomes e, even when e is below 12.
- R8: `irq` is a one-cycle pulse raised only by the completion of an extra conversion.
- R9: Each sequence or single completion raises a one-cycle pulse on `dma_ch[c]` for its channel c, together with `dma_all`. An extra conversion raises neither.
- R10: An extra-channel write that arrives while a sequence conversion is running is held pending. It runs right after the current conversion, and the sequence then resumes at the next channel.
- R11: A channel-select write that arrives while a conversion is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select: 0 channel-select, 1 extra channel, 2 decimation |
| wr_data | input | 4 | Write data |
| rd_hi | input | 1 | High result byte read strobe (clears eoc) |
| sample_in | input | 12 | Signed sample from the converter model |
| conv_ch | output | 4 | Channel currently fed to the converter |
| result | output | 16 | Left-justified conversion result |
| eoc | output | 1 | End-of-conversion flag |
| sch_rd | output | 4 | Channel-select readback |
| irq | output | 1 | Extra-conversion completion pulse |
| dma_ch | output | 16 | Per-channel DMA trigger pulses |
| dma_all | output | 1 | Shared DMA trigger pulse |

## Verification
The assertions assume that `sample_in` is stable while a conversion completes and that two completions are never closer than six cycles, so each pulse drops before the next one. They also assume that no extra conversion is requested while another extra is already running or pending. The stimulus changes the decimation code and the sample model only while the block is idle. It issues at most one extra write per sequence, and it strobes `rd_hi` only after all activity has stopped. Random channel-select values cover both sequence and single modes, and directed cases cover the remaining boundaries.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int CH_W           = 4;
    localparam int NUM_CH         = 1 << CH_W;
    localparam int SETTLE_PERIODS = 16;
    localparam int RES_W          = 16;
    localparam int CNT_W          = 10;
    localparam logic [CH_W-1:0] SINGLE_MIN = CH_W'(12);

    typedef enum logic [1:0] {
        SEL_CHAN  = 2'd0,
        SEL_EXTRA = 2'd1,
        SEL_DECIM = 2'd2,
        SEL_NONE  = 2'd3
    } wsel_e;

    typedef struct packed {
        logic            extra;
        logic            seq;
        logic [CH_W-1:0] ch;
    } job_t;

    typedef struct packed {
        logic valid;
        job_t job;
    } fin_t;

    // converter periods for one conversion: settle + decimation length
    function automatic logic [CNT_W-1:0] periods_for(input logic [1:0] code);
        return CNT_W'(SETTLE_PERIODS) + (CNT_W'(64) << code);
    endfunction
endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer
    import adcseq_pkg::*;
#(
    parameter int DIV = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] periods,
    output logic             done
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic             run_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic             tick;

    assign tick = run_q && (div_q == DIV_W'(DIV - 1));
    assign done = tick && (cnt_q == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            div_q <= '0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            div_q <= '0;
            cnt_q <= '0;
            len_q <= periods;
        end else if (run_q) begin
            if (tick) begin
                div_q <= '0;
                if (done) run_q <= 1'b0;
                else      cnt_q <= cnt_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (div_q < DIV_W'(DIV))); // R1
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !run_q); // R1
endmodule

// File: rtl/adcseq_sched.sv
module adcseq_sched
    import adcseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [CH_W-1:0] wr_data,
    input  logic            done,
    output logic            start,
    output logic            chan_accept,
    output job_t            cur,
    output fin_t            fin
);
    logic            busy_q, left_q, pend_q;
    job_t            cur_q, next_job;
    logic [CH_W-1:0] seq_end_q, nxt_q, pend_ch_q;
    logic            wr_chan, wr_extra, pend_now, left_after;
    logic [CH_W-1:0] pend_ch_now, nxt_after;

    assign wr_chan     = wr_en && (wr_sel == SEL_CHAN);
    assign wr_extra    = wr_en && (wr_sel == SEL_EXTRA);
    assign chan_accept = wr_chan && !busy_q;
    assign pend_now    = pend_q || (wr_extra && busy_q && !cur_q.extra);
    assign pend_ch_now = pend_q ? pend_ch_q : wr_data;
    assign left_after  = cur_q.extra ? left_q
                                     : (cur_q.seq && (cur_q.ch != seq_end_q));
    assign nxt_after   = cur_q.extra ? nxt_q : cur_q.ch + 1'b1;
    assign cur         = cur_q;
    assign fin.valid   = done;
    assign fin.job     = cur_q;

    always_comb begin
        start    = 1'b0;
        next_job = cur_q;
        if (!busy_q) begin
            if (wr_chan) begin
                start          = 1'b1;
                next_job.extra = 1'b0;
                next_job.seq   = (wr_data < SINGLE_MIN);
                next_job.ch    = (wr_data < SINGLE_MIN) ? '0 : wr_data;
            end else if (wr_extra) begin
                start    = 1'b1;
                next_job = '{extra: 1'b1, seq: 1'b0, ch: wr_data};
            end
        end else if (done) begin
            if (pend_now) begin
                start    = 1'b1;
                next_job = '{extra: 1'b1, seq: 1'b0, ch: pend_ch_now};
            end else if (left_after) begin
                start    = 1'b1;
                next_job = '{extra: 1'b0, seq: 1'b1, ch: nxt_after};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            left_q    <= 1'b0;
            pend_q    <= 1'b0;
            cur_q     <= '0;
            seq_end_q <= '0;
            nxt_q     <= '0;
            pend_ch_q <= '0;
        end else begin
            if (!busy_q) begin
                left_q <= 1'b0;
                pend_q <= 1'b0;
                if (wr_chan) seq_end_q <= wr_data;
            end else if (done) begin
                left_q <= left_after;
                nxt_q  <= nxt_after;
                pend_q <= 1'b0;
            end else begin
                pend_q    <= pend_now;
                pend_ch_q <= pend_ch_now;
            end
            if (start) begin
                busy_q <= 1'b1;
                cur_q  <= next_job;
            end else if (busy_q && done) begin
                busy_q <= 1'b0;
            end
        end
    end

    AST_PEND_NOT_NESTED: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !cur_q.extra); // R10
    AST_SEQ_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (done && cur_q.seq && !cur_q.extra && (cur_q.ch != seq_end_q)) |=> busy_q); // R5
    AST_CHAN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && wr_chan) |=> $stable(seq_end_q)); // R11
endmodule

// File: rtl/adcseq_result.sv
module adcseq_result
    import adcseq_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  fin_t                       fin,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic                       rd_hi,
    input  logic                       sch_wr,
    input  logic [CH_W-1:0]            sch_wr_val,
    output logic [RES_W-1:0]           result,
    output logic                       eoc,
    output logic [CH_W-1:0]            sch_rd,
    output logic                       irq,
    output logic [NUM_CH-1:0]          dma_ch,
    output logic                       dma_all
);
    localparam int SHIFT = RES_W - SAMPLE_W;

    logic [RES_W-1:0] aligned;
    assign aligned = RES_W'(unsigned'(sample_in)) << SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            eoc     <= 1'b0;
            sch_rd  <= '0;
            irq     <= 1'b0;
            dma_all <= 1'b0;
        end else begin
            irq     <= fin.valid && fin.job.extra;
            dma_all <= fin.valid && !fin.job.extra;
            if (fin.valid) begin
                result <= aligned;
                eoc    <= 1'b1;
                sch_rd <= fin.job.seq ? fin.job.ch + 1'b1 : fin.job.ch;
            end else begin
                if (rd_hi)  eoc    <= 1'b0;
                if (sch_wr) sch_rd <= sch_wr_val;
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dma
        always_ff @(posedge clk) begin
            if (rst) dma_ch[g] <= 1'b0;
            else     dma_ch[g] <= fin.valid && !fin.job.extra && (fin.job.ch == CH_W'(g));
        end
    end

    AST_IRQ_EXCL_DMA: assert property (@(posedge clk) disable iff (rst)
        irq |-> !dma_all); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R8
    AST_DMA_ONE_CH: assert property (@(posedge clk) disable iff (rst)
        dma_all |-> ($countones(dma_ch) == 1)); // R9
    AST_EOC_SET: assert property (@(posedge clk) disable iff (rst)
        fin.valid |=> eoc); // R4
    AST_EOC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !fin.valid) |=> !eoc); // R4
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        result[SHIFT-1:0] == '0); // R3
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int DIV      = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [3:0]                 wr_data,
    input  logic                       rd_hi,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic [3:0]                 conv_ch,
    output logic [15:0]                result,
    output logic                       eoc,
    output logic [3:0]                 sch_rd,
    output logic                       irq,
    output logic [15:0]                dma_ch,
    output logic                       dma_all
);
    logic [1:0] dec_q;
    logic       start, done, chan_accept;
    job_t       cur;
    fin_t       fin;

    always_ff @(posedge clk) begin
        if (rst)                                dec_q <= 2'd0;
        else if (wr_en && wr_sel == SEL_DECIM) dec_q <= wr_data[1:0];
    end

    adcseq_sched u_sched (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .done(done), .start(start), .chan_accept(chan_accept), .cur(cur), .fin(fin)
    );

    adcseq_timer #(.DIV(DIV)) u_timer (
        .clk(clk), .rst(rst), .start(start), .periods(periods_for(dec_q)), .done(done)
    );

    adcseq_result #(.SAMPLE_W(SAMPLE_W)) u_result (
        .clk(clk), .rst(rst), .fin(fin), .sample_in(sample_in), .rd_hi(rd_hi),
        .sch_wr(chan_accept), .sch_wr_val(wr_data), .result(result), .eoc(eoc),
        .sch_rd(sch_rd), .irq(irq), .dma_ch(dma_ch), .dma_all(dma_all)
    );

    assign conv_ch = cur.ch;
endmodule

// File: tb/tb_adcseq_top.sv
`timescale 1ns/1ps
module tb_adcseq_top;
    logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_hi = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [3:0]  wr_data = 4'd0;
    logic signed [11:0] sample_in;
    logic [3:0]  conv_ch, sch_rd;
    logic [15:0] result, dma_ch;
    logic        eoc, irq, dma_all;

    int tests = 0, fails = 0, cyc = 0, salt = 0, bad = 0, wcyc = 0;
    int ev_n = 0;
    int ev_ch[64];
    bit ev_x[64];
    logic [15:0] ev_res[64];
    int ev_cyc[64];
    bit finished = 1'b0, prev_irq = 1'b0;

    always #4 clk = ~clk;

    adcseq_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_hi(rd_hi), .sample_in(sample_in), .conv_ch(conv_ch), .result(result),
        .eoc(eoc), .sch_rd(sch_rd), .irq(irq), .dma_ch(dma_ch), .dma_all(dma_all)
    );

    function automatic logic signed [11:0] model(input logic [3:0] ch, input int s);
        return 12'(s + int'(ch) * 293 - 1500);
    endfunction

    function automatic int one_idx(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return -1;
    endfunction

    assign sample_in = model(conv_ch, salt);

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (irq && prev_irq) bad++;
            prev_irq = irq;
            if (dma_all || irq) begin
                if (irq && dma_all) bad++;
                if (dma_all && $countones(dma_ch) != 1) bad++;
                if (irq && dma_ch != 16'd0) bad++;
                if (ev_n < 64) begin
                    ev_ch[ev_n]  = irq ? int'(sch_rd) : one_idx(dma_ch);
                    ev_x[ev_n]   = irq;
                    ev_res[ev_n] = result;
                    ev_cyc[ev_n] = cyc;
                end
                ev_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wcyc = cyc;
    endtask

    function automatic int period6(input int dcode);
        return 6 * (16 + (64 << dcode));
    endfunction

    task automatic check_event(input int i, input int ch, input bit x, input int t);
        chk(ev_ch[i] == ch, x ? "R7 channel" : "R5/R6 channel", ev_ch[i], ch);
        chk(ev_x[i] == x, x ? "R8 irq kind" : "R9 dma kind", ev_x[i], x);
        chk(ev_cyc[i] == t, "R1 timing", ev_cyc[i] - wcyc, t - wcyc);
        chk(ev_res[i] == {model(4'(ch), salt), 4'b0000}, "R3 result",
            int'(ev_res[i]), int'({model(4'(ch), salt), 4'b0000}));
    endtask

    task automatic run_chan(input int v, input int dcode);
        int p, n;
        p = period6(dcode);
        n = (v < 12) ? v + 1 : 1;
        ev_n = 0; bad = 0;
        wr(2'd0, 4'(v));
        repeat (n * p + 10) @(negedge clk);
        chk(ev_n == n, "R5/R6 count", ev_n, n);
        for (int i = 0; i < n && i < 64; i++)
            check_event(i, (v < 12) ? i : v, 1'b0, wcyc + (i + 1) * p);
        chk(int'(sch_rd) == ((v < 12) ? v + 1 : v), (v < 12) ? "R5 readback" : "R6 readback",
            int'(sch_rd), (v < 12) ? v + 1 : v);
        chk(bad == 0, "R8/R9 pulses", bad, 0);
        chk(eoc == 1'b1, "R4 eoc set", eoc, 1);
        @(negedge clk); rd_hi = 1'b1;
        @(negedge clk); rd_hi = 1'b0;
        chk(eoc == 1'b0, "R4 eoc clear", eoc, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(2024);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result == 16'd0 && eoc == 1'b0 && sch_rd == 4'd0, "R4 reset regs",
            int'(result) + int'(eoc) + int'(sch_rd), 0);
        chk(!irq && dma_ch == 16'd0 && !dma_all, "R4 reset pulses", int'(dma_ch), 0);

        // R6 single conversion at reset decimation (R2 default 64)
        salt = 100;  run_chan(12, 0);
        // R2 decimation 128 and 512
        wr(2'd2, 4'd1); salt = 3000; run_chan(13, 1);
        wr(2'd2, 4'd3); salt = 777;  run_chan(14, 3);
        wr(2'd2, 4'd0);
        // R5 sequence 0..4 and negative samples
        salt = 2500; run_chan(4, 0);
        salt = 0;    run_chan(0, 0);

        // R7/R8 extra conversion from idle with low channel
        ev_n = 0; bad = 0; salt = 1234;
        wr(2'd1, 4'd3);
        repeat (period6(0) + 10) @(negedge clk);
        chk(ev_n == 1, "R7 extra count", ev_n, 1);
        check_event(0, 3, 1'b1, wcyc + period6(0));
        chk(sch_rd == 4'd3, "R7 readback", int'(sch_rd), 3);
        chk(bad == 0, "R8 irq only, R9 no dma", bad, 0);

        // R11 channel-select write while busy is ignored
        ev_n = 0; bad = 0; salt = 55;
        wr(2'd0, 4'd2);
        begin
            int w0;
            w0 = wcyc;
            repeat (50) @(negedge clk);
            wr(2'd0, 4'd13);
            wcyc = w0;
        end
        repeat (3 * period6(0) + 20) @(negedge clk);
        chk(ev_n == 3, "R11 count", ev_n, 3);
        for (int i = 0; i < 3; i++) check_event(i, i, 1'b0, wcyc + (i + 1) * period6(0));
        chk(sch_rd == 4'd3, "R11 readback", int'(sch_rd), 3);

        // R10 pending extra during sequence
        ev_n = 0; bad = 0; salt = 4000;
        wr(2'd0, 4'd3);
        begin
            int w0;
            w0 = wcyc;
            repeat (100) @(negedge clk);
            wr(2'd1, 4'd14);
            wcyc = w0;
        end
        repeat (5 * period6(0) + 20) @(negedge clk);
        chk(ev_n == 5, "R10 count", ev_n, 5);
        check_event(0, 0, 1'b0, wcyc + 1 * period6(0));
        check_event(1, 14, 1'b1, wcyc + 2 * period6(0));
        check_event(2, 1, 1'b0, wcyc + 3 * period6(0));
        check_event(3, 2, 1'b0, wcyc + 4 * period6(0));
        check_event(4, 3, 1'b0, wcyc + 5 * period6(0));
        chk(sch_rd == 4'd4, "R10 readback", int'(sch_rd), 4);
        chk(bad == 0, "R10 pulses", bad, 0);

        // random mix of modes
        for (int it = 0; it < 8; it++) begin
            int dcode, v;
            dcode = int'($urandom % 2);
            v     = int'($urandom % 16);
            salt  = int'($urandom % 4096);
            wr(2'd2, 4'(dcode));
            run_chan(v, dcode);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule